// File: doc/BRIEF.md
# RAM-Based Programmable Word Delay Line

This block delays a serial bit stream by whole data words and brings out four taps: one, two, three and four words behind the input. The word length is programmable as any even number from 2 to 32 bits. Bits arrive one per full-rate beat, marked by a valid strobe. The block gathers them into pairs, so its memories work at half the bit rate.

Each of the two chained stages holds a small RAM that is four bits wide. One address counter, shared by both stages, steps through half a word's worth of locations. On every pair beat, a stage reads the addressed location into a holding register. It then writes the new pair into the low two columns. The pair it has just read moves into the high two columns. This recycling makes the high columns exactly one word older than the low columns. The second stage takes its input from the first stage's oldest pair, which adds two more words of delay. A 2:1 selector on every register pair turns the pairs back into serial bits in their original order.

The word length is given as a length code. The word length is 2×(code+1) bits, and the counter wraps when it equals the code. The code is captured only while reset is asserted. The sync search logic and the pair splitter that feed a full line are not part of this block.

Top module: `wdl_delay_line`

## Requirements
- R1: A synchronous active-high reset drives all four tap outputs to 0, sets the pair phase to "first bit" and sets the address counter to 0.
- R2: The length code `len_code` is captured only during reset. The word length L is 2×(code+1). Changing `len_code` outside reset has no effect on any tap.
- R3: Number the accepted input bits j = 0, 1, 2, and so on. After the clock edge that accepts bit j, `dly_o[0]` holds input bit j-1-L.
- R4: After the clock edge that accepts bit j, `dly_o[1]` holds input bit j-1-2L, exactly one word behind `dly_o[0]`.
- R5: After the clock edge that accepts bit j, `dly_o[2]` holds input bit j-1-3L and `dly_o[3]` holds input bit j-1-4L. These taps come from the second stage.
- R6: A cycle with `in_valid` low changes no state: all taps hold their values, and neither the pair phase nor the address advances.
- R7: The address advances once per completed pair. It never exceeds the captured code, and it returns to 0 on the pair after the one at which it equals the code.
- R8: The shortest word (code 0, L = 2) and the longest word (code 15, L = 32) both meet R3 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate bit clock |
| rst | input | 1 | Synchronous active-high reset; also loads the length code |
| len_code | input | 4 | Word length code; L = 2×(code+1) bits |
| in_valid | input | 1 | Marks a beat that carries an input bit |
| in_bit | input | 1 | Serial input data bit |
| dly_o | output | 4 | Serial taps; bit k-1 is the input delayed by k words |

## Verification
Every length code from 0 to 15 is swept. Each run feeds a pseudo-random bit stream with random idle gaps. The random data shows up any error in bit order within a pair, and any error of one word in tap spacing. The sweep over all codes exposes an off-by-one at the address wrap. The idle gaps separate the valid-gated update from a free-running one. In each run the length code is changed to a different value right after reset, which shows whether the code is captured only during reset.

// File: rtl/wdl_pkg.sv
package wdl_pkg;
  localparam int COLS = 4;
  typedef logic [COLS-1:0] quad_t;
endpackage

// File: rtl/wdl_addr_ctr.sv
module wdl_addr_ctr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] len_code,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] len_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      len_q <= len_code;
    end else if (adv) begin
      addr <= (addr == len_q) ? '0 : addr + 1'b1;
    end
  end
endmodule

// File: rtl/wdl_ram_stage.sv
module wdl_ram_stage
  import wdl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        din,
  output quad_t             stor
);
  localparam int DEPTH = 2 ** ADDR_W;

  quad_t mem [DEPTH];

  // column 0/1: newest pair, column 2/3: pair recycled from the last read
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= {stor[1:0], din};
  end

  always_ff @(posedge clk) begin
    if (rst)        stor <= '0;
    else if (rd_en) stor <= mem[addr];
  end
endmodule

// File: rtl/wdl_pair_ser.sv
module wdl_pair_ser (
  input  logic clk,
  input  logic rst,
  input  logic vld,
  input  logic phase,
  input  logic bit_a,
  input  logic bit_b,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (vld) q <= phase ? bit_a : bit_b;
  end
endmodule

// File: rtl/wdl_delay_line.sv
module wdl_delay_line
  import wdl_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int NUM_STAGES = 2,
  localparam int TAPS      = 2 * NUM_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] len_code,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic [TAPS-1:0]   dly_o
);
  logic              phase_q;
  logic              first_q;
  logic              rd_en;
  logic              wr_en;
  logic [ADDR_W-1:0] addr_w;
  logic [ADDR_W-1:0] len_w;
  quad_t             stor_w [NUM_STAGES];
  logic [1:0]        din_w  [NUM_STAGES];

  assign rd_en = in_valid & ~phase_q;
  assign wr_en = in_valid &  phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      first_q <= 1'b0;
    end else if (in_valid) begin
      phase_q <= ~phase_q;
      if (!phase_q) first_q <= in_bit;
    end
  end

  wdl_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst(rst), .len_code(len_code), .adv(wr_en),
    .addr(addr_w), .len_q(len_w)
  );

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign din_w[s] = {in_bit, first_q};
    end else begin : g_chain
      assign din_w[s] = stor_w[s-1][3:2];
    end

    wdl_ram_stage #(.ADDR_W(ADDR_W)) u_ram (
      .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
      .addr(addr_w), .din(din_w[s]), .stor(stor_w[s])
    );

    wdl_pair_ser u_ser_lo (
      .clk(clk), .rst(rst), .vld(in_valid), .phase(phase_q),
      .bit_a(stor_w[s][0]), .bit_b(stor_w[s][1]), .q(dly_o[2*s])
    );

    wdl_pair_ser u_ser_hi (
      .clk(clk), .rst(rst), .vld(in_valid), .phase(phase_q),
      .bit_a(stor_w[s][2]), .bit_b(stor_w[s][3]), .q(dly_o[2*s+1])
    );
  end
endmodule

// File: rtl/wdl_delay_line_chk.sv
module wdl_delay_line_chk #(
  parameter int ADDR_W = 4,
  parameter int TAPS   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              phase,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] len_q,
  input logic [TAPS-1:0]   dly
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dly == '0 && addr == '0 && !phase));

  // R2
  len_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(len_q));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(dly) && $stable(addr) && $stable(phase)));

  // R7
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    addr <= len_q);

  // R7
  addr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && phase && addr == len_q) |=> addr == '0);
endmodule

bind wdl_delay_line wdl_delay_line_chk #(.ADDR_W(ADDR_W), .TAPS(TAPS)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .phase(phase_q),
  .addr(addr_w), .len_q(len_w), .dly(dly_o)
);

// File: tb/wdl_delay_line_bench.sv
module wdl_delay_line_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] len_code = '0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic [3:0] dly_o;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;
  bit hist [0:511];
  logic [31:0] rng = 32'h1badcafe;

  always #10 clk = ~clk;

  wdl_delay_line u_wdl_delay_line (
    .clk(clk), .rst(rst), .len_code(len_code),
    .in_valid(in_valid), .in_bit(in_bit), .dly_o(dly_o)
  );

  task automatic step_rng();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
  endtask

  task automatic chk(string req, int act, int expv);
    nvec++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  task automatic run(int code, int other);
    int L;
    int nbeats;
    int j;
    logic [3:0] prev;
    string pre;
    L = 2 * (code + 1);
    nbeats = 4 * L + 40;
    pre = (code == 0 || code == 15) ? "R8 " : "";
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; len_code = 4'(code);
    repeat (2) @(negedge clk);
    // R1: taps cleared by reset
    chk($sformatf("R1 code=%0d", code), int'(dly_o), 0);
    rst = 1'b0;
    // R2: code change outside reset must be ignored
    len_code = 4'(other);
    j = 0;
    while (j < nbeats) begin
      step_rng();
      in_valid = (rng[2:0] != 3'd5);
      in_bit = rng[9];
      prev = dly_o;
      if (in_valid) hist[j] = in_bit;
      @(negedge clk);
      if (in_valid) begin
        // R7 is observed through exact word spacing for every code
        for (int k = 1; k <= 4; k++) begin
          int idx;
          string tg;
          idx = j - 1 - k * L;
          tg = (k == 1) ? "R3" : (k == 2) ? "R4" : "R5";
          if (idx >= 0)
            chk($sformatf("%s%s/R2 code=%0d tap%0d beat%0d", pre, tg, code, k, j),
                int'(dly_o[k-1]), int'(hist[idx]));
        end
        j++;
      end else begin
        chk($sformatf("R6 code=%0d beat%0d", code, j), int'(dly_o), int'(prev));
      end
    end
    in_valid = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 16; c++) run(c, 15 - c);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog all-reqs act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule